// File: doc/BRIEF.md
# Reader Write Command Framer

This block sends one write command from a reader to a tag over a pause-coded downlink and then judges whether the tag acknowledged it. A host presents a byte address, a data byte, a 4-bit checksum it has already computed, and an address-width select, then pulses a start strobe. The block latches the fields and packs them into a serial frame whose length follows the address width. After a fixed guard interval it shifts the frame out least significant bit first. Each bit is a short low pause followed by a high mark, and the mark length tells a one from a zero.

When the frame is finished the block waits a long fixed interval, during which the tag line is ignored. It then opens a bounded listening window for the tag's single acknowledge bit. The result is reported as a one-cycle done pulse together with an OK flag. The OK flag holds until the next command is accepted. All timing counts ticks of a prescaled clock (`CLKS_PER_TICK` clock cycles per tick, 1.5 ticks per microsecond in the intended system). Checksum generation, keystream whitening and carrier modulation are handled elsewhere.

Top module: `wr_cmd_framer`

## Requirements
- R1: The frame has 13 + A bits, where A = 7 when `long_addr_i` = 0 and A = 10 when `long_addr_i` = 1 (20 or 23 bits). In 7-bit mode, address bits 9..7 have no effect on the frame.
- R2: The frame is sent LSB first. Frame bit 0 is the write command bit (value 0). Bits 1..A carry address bits 0..A-1, bits A+1..A+8 carry the data byte, and bits A+9..A+12 carry checksum bits 0..3.
- R3: After a start is accepted, `tx_o` stays high for exactly 240 ticks before the first pause begins.
- R4: Every frame bit begins with a 30-tick low pause on `tx_o`. The high mark that follows lasts 120 ticks for a 1 and 60 ticks for a 0. One further 30-tick closing pause follows the last bit, and then `tx_o` returns high. `tx_o` is low only while busy.
- R5: The acknowledge window opens 5400 ticks after the closing pause ends and lasts 300 ticks. A 1 sampled on `ack_i` in any window cycle raises `done_o` with `ok_o` = 1 in the next cycle. `ok_o` changes only in a done cycle or when a new command is accepted, which clears it.
- R6: `ack_i` high before the window opens is ignored.
- R7: If no 1 is sampled in the window, `done_o` rises with `ok_o` = 0 in the cycle right after the last window cycle.
- R8: A 1 on `ack_i` in the last window cycle counts as an acknowledge and yields `ok_o` = 1, not a timeout.
- R9: `busy_o` is high from the cycle after an accepted start through the done cycle, inclusive. `done_o` is high for exactly one cycle per command, and only while `busy_o` is high.
- R10: A start strobe while `busy_o` is high is ignored, including a strobe in the done cycle. The frame in progress is unchanged, and the block is idle in the cycle after done.
- R11: After reset, `tx_o` = 1 and `busy_o`, `done_o` and `ok_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| long_addr_i | input | 1 | 0 selects 7-bit address, 1 selects 10-bit address |
| addr_i | input | 10 | Byte address |
| data_i | input | 8 | Data byte to write |
| crc_i | input | 4 | Checksum supplied by the host |
| ack_i | input | 1 | Demodulated tag response level, synchronous to clk |
| tx_o | output | 1 | Serial downlink, low during pauses |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Acknowledge seen, valid from done until next start |

## Verification
Two functions meet in a single cycle at the end of the acknowledge window: the window timeout and the arrival of the acknowledge. The bench raises `ack_i` only in the last window cycle, counted from the rising edge that ends the closing pause. It then requires `done_o` one cycle later with `ok_o` = 1. The second meeting point is the done cycle, where completion coincides with a fresh start strobe. The bench drives start in exactly that cycle and requires the block to be idle, with `tx_o` high, in the next cycle.

// File: rtl/wcf_pkg.sv
package wcf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GUARD,
        ST_PAUSE,
        ST_MARK,
        ST_CLOSE,
        ST_DELAY,
        ST_WIN,
        ST_FIN
    } wcf_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wcf_tick_gen.sv
module wcf_tick_gen #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_every_cycle
            logic run_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) run_q <= 1'b0;
                else        run_q <= 1'b1;
            end
            assign tick_o = run_q;
        end else begin : g_divided
            localparam int DW = $clog2(DIV);
            logic [DW-1:0] div_d, div_q;
            always_comb begin
                if (div_q == DW'(DIV - 1)) div_d = '0;
                else                       div_d = div_q + 1'b1;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) div_q <= '0;
                else        div_q <= div_d;
            end
            assign tick_o = (div_q == DW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/wcf_frame_pack.sv
module wcf_frame_pack #(
    parameter int   SHORT_A   = 7,
    parameter int   LONG_A    = 10,
    parameter logic WR_BIT    = 1'b0,
    parameter int   FRAME_MAX = LONG_A + 13,
    parameter int   IDX_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic [LONG_A-1:0]    addr_i,
    input  logic [7:0]           data_i,
    input  logic [3:0]           crc_i,
    input  logic                 long_i,
    output logic [FRAME_MAX-1:0] frame_o,
    output logic [IDX_W-1:0]     len_o
);

    localparam int SHORT_LEN = SHORT_A + 13;
    localparam int PAD       = FRAME_MAX - SHORT_LEN;

    logic [FRAME_MAX-1:0] frame_long;
    logic [FRAME_MAX-1:0] frame_short;

    assign frame_long = {crc_i, data_i, addr_i, WR_BIT};

    generate
        if (PAD > 0) begin : g_pad
            assign frame_short = {{PAD{1'b0}}, crc_i, data_i, addr_i[SHORT_A-1:0], WR_BIT};
        end else begin : g_nopad
            assign frame_short = {crc_i, data_i, addr_i[SHORT_A-1:0], WR_BIT};
        end
    endgenerate

    always_comb begin
        if (long_i) begin
            frame_o = frame_long;
            len_o   = IDX_W'(FRAME_MAX);
        end else begin
            frame_o = frame_short;
            len_o   = IDX_W'(SHORT_LEN);
        end
    end

endmodule

// File: rtl/wr_cmd_framer.sv
module wr_cmd_framer #(
    parameter int CLKS_PER_TICK   = 32,
    parameter int SHORT_A         = 7,
    parameter int LONG_A          = 10,
    parameter int GUARD_TICKS     = 240,
    parameter int PAUSE_TICKS     = 30,
    parameter int ONE_BIT_TICKS   = 150,
    parameter int ZERO_BIT_TICKS  = 90,
    parameter int ACK_DELAY_TICKS = 5400,
    parameter int ACK_WIN_TICKS   = 300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              long_addr_i,
    input  logic [LONG_A-1:0] addr_i,
    input  logic [7:0]        data_i,
    input  logic [3:0]        crc_i,
    input  logic              ack_i,
    output logic              tx_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              ok_o
);
    import wcf_pkg::*;

    localparam int FRAME_MAX = LONG_A + 13;
    localparam int IDX_W     = $clog2(FRAME_MAX + 1);
    localparam int ONE_MARK  = ONE_BIT_TICKS - PAUSE_TICKS;
    localparam int ZERO_MARK = ZERO_BIT_TICKS - PAUSE_TICKS;
    localparam int MAX_T     = max2(max2(ACK_DELAY_TICKS, ACK_WIN_TICKS),
                                    max2(GUARD_TICKS, ONE_MARK));
    localparam int CNT_W     = $clog2(MAX_T + 1);

    typedef struct packed {
        wcf_state_e           st;
        logic [CNT_W-1:0]     cnt;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     nbits;
        logic [FRAME_MAX-1:0] sh;
        logic                 ok;
    } regs_t;

    regs_t regs_d, regs_q;

    logic                 tick;
    logic [FRAME_MAX-1:0] packed_frame;
    logic [IDX_W-1:0]     packed_len;
    logic                 mark_end;
    logic                 last_bit;

    wcf_tick_gen #(
        .DIV (CLKS_PER_TICK)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    wcf_frame_pack #(
        .SHORT_A   (SHORT_A),
        .LONG_A    (LONG_A),
        .WR_BIT    (1'b0),
        .FRAME_MAX (FRAME_MAX),
        .IDX_W     (IDX_W)
    ) u_pack (
        .addr_i  (addr_i),
        .data_i  (data_i),
        .crc_i   (crc_i),
        .long_i  (long_addr_i),
        .frame_o (packed_frame),
        .len_o   (packed_len)
    );

    assign mark_end = regs_q.sh[0] ? (regs_q.cnt == CNT_W'(ONE_MARK - 1))
                                   : (regs_q.cnt == CNT_W'(ZERO_MARK - 1));
    assign last_bit = (regs_q.idx == regs_q.nbits - 1'b1);

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    regs_d.st    = ST_GUARD;
                    regs_d.cnt   = '0;
                    regs_d.idx   = '0;
                    regs_d.nbits = packed_len;
                    regs_d.sh    = packed_frame;
                    regs_d.ok    = 1'b0;
                end
            end
            ST_GUARD: begin
                if (tick) begin
                    if (regs_q.cnt == CNT_W'(GUARD_TICKS - 1)) begin
                        regs_d.st  = ST_PAUSE;
                        regs_d.cnt = '0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAUSE: begin
                if (tick) begin
                    if (regs_q.cnt == CNT_W'(PAUSE_TICKS - 1)) begin
                        regs_d.st  = ST_MARK;
                        regs_d.cnt = '0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            ST_MARK: begin
                if (tick) begin
                    if (mark_end) begin
                        regs_d.cnt = '0;
                        regs_d.sh  = regs_q.sh >> 1;
                        regs_d.idx = regs_q.idx + 1'b1;
                        regs_d.st  = last_bit ? ST_CLOSE : ST_PAUSE;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            ST_CLOSE: begin
                if (tick) begin
                    if (regs_q.cnt == CNT_W'(PAUSE_TICKS - 1)) begin
                        regs_d.st  = ST_DELAY;
                        regs_d.cnt = '0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            ST_DELAY: begin
                if (tick) begin
                    if (regs_q.cnt == CNT_W'(ACK_DELAY_TICKS - 1)) begin
                        regs_d.st  = ST_WIN;
                        regs_d.cnt = '0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            ST_WIN: begin
                if (ack_i) begin
                    regs_d.st = ST_FIN;
                    regs_d.ok = 1'b1;
                end else if (tick) begin
                    if (regs_q.cnt == CNT_W'(ACK_WIN_TICKS - 1)) begin
                        regs_d.st = ST_FIN;
                        regs_d.ok = 1'b0;
                    end else begin
                        regs_d.cnt = regs_q.cnt + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                regs_d.st  = ST_IDLE;
                regs_d.cnt = '0;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, cnt: '0, idx: '0, nbits: '0, sh: '0, ok: 1'b0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign tx_o   = !((regs_q.st == ST_PAUSE) || (regs_q.st == ST_CLOSE));
    assign busy_o = (regs_q.st != ST_IDLE);
    assign done_o = (regs_q.st == ST_FIN);
    assign ok_o   = regs_q.ok;

endmodule

// File: rtl/wcf_checker.sv
module wcf_checker #(
    parameter int PAUSE_CYC = 30
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic tx_o,
    input logic busy_o,
    input logic done_o,
    input logic ok_o
);

    logic [15:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_cnt_q <= '0;
        else if (!tx_o) low_cnt_q <= (low_cnt_q == 16'hFFFF) ? low_cnt_q : low_cnt_q + 1'b1;
        else            low_cnt_q <= '0;
    end

    AST_PAUSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_o) |-> (low_cnt_q == 16'(PAUSE_CYC))); // R4

    AST_LOW_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_o |-> busy_o); // R4

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R9

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R9

    AST_START_AT_DONE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> !busy_o); // R10

    AST_START_IN_FLIGHT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o); // R10

    AST_OK_CHANGE_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ok_o) |-> (done_o || busy_o)); // R5

endmodule

bind wr_cmd_framer wcf_checker #(
    .PAUSE_CYC (PAUSE_TICKS * CLKS_PER_TICK)
) u_wcf_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .tx_o    (tx_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .ok_o    (ok_o)
);

// File: tb/test_wr_cmd_framer.sv
module test_wr_cmd_framer;

    localparam int D = 5400;
    localparam int W = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       long_addr_i = 1'b0;
    logic [9:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic [3:0] crc_i = '0;
    logic       ack_i = 1'b0;
    logic       tx_o, busy_o, done_o, ok_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wr_cmd_framer #(.CLKS_PER_TICK(1)) i_wr_cmd_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .long_addr_i (long_addr_i),
        .addr_i      (addr_i),
        .data_i      (data_i),
        .crc_i       (crc_i),
        .ack_i       (ack_i),
        .tx_o        (tx_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ok_o        (ok_o)
    );

    task automatic chk(input bit cond, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [22:0] exp_frame(input logic [9:0] a, input logic [7:0] d,
                                              input logic [3:0] c, input bit lng);
        logic [22:0] e = '0;
        int aw = lng ? 10 : 7;
        for (int j = 0; j < aw; j++) e[1 + j] = a[j];
        for (int j = 0; j < 8; j++)  e[aw + 1 + j] = d[j];
        for (int j = 0; j < 4; j++)  e[aw + 9 + j] = c[j];
        return e;
    endfunction

    task automatic check_reset();
        chk(tx_o == 1'b1, "R11", "tx after reset", int'(tx_o), 1);
        chk(busy_o == 1'b0, "R11", "busy after reset", int'(busy_o), 0);
        chk(done_o == 1'b0, "R11", "done after reset", int'(done_o), 0);
        chk(ok_o == 1'b0, "R11", "ok after reset", int'(ok_o), 0);
    endtask

    // One command: ack_i is high for window-relative cycles lo..hi (k = 0 is the
    // first high cycle after the closing pause).
    task automatic run_cmd(input logic [9:0] a, input logic [7:0] d, input logic [3:0] c,
                           input bit lng, input int lo, input int hi,
                           input bit exp_ok, input int exp_k,
                           input bit poke_busy, input bit poke_done, input string name);
        int n = lng ? 23 : 20;
        logic [22:0] exp = exp_frame(a, d, c, lng);
        logic [22:0] got = '0;
        int run = 1, falls = 0, guard = -1, bad_pause = 0, bad_mark = 0, extra = 0;
        int endc = -1, done_k = -1, cyc = 0;
        logic prev = 1'b1;
        logic got_ok = 1'b0;

        @(negedge clk);
        long_addr_i = lng; addr_i = a; data_i = d; crc_i = c; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9", {name, " busy after start"}, int'(busy_o), 1);
        chk(ok_o == 1'b0, "R5", {name, " ok cleared on accept"}, int'(ok_o), 0);

        while (cyc < 14000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 100 && poke_busy) begin
                start_i = 1'b1; addr_i = ~a; data_i = ~d; crc_i = ~c;
            end else if (cyc == 101 && poke_busy) begin
                start_i = 1'b0;
            end
            if (tx_o == prev) begin
                run++;
            end else begin
                if (prev) begin
                    if (falls == 0) guard = run;
                    else if (falls <= n) begin
                        if (run == 120)     got[falls - 1] = 1'b1;
                        else if (run != 60) bad_mark++;
                    end
                end else begin
                    falls++;
                    if (run != 30) bad_pause++;
                    if (falls == n + 1) endc = cyc;
                    if (falls > n + 1) extra++;
                end
                run = 1;
                prev = tx_o;
            end
            if (endc >= 0) ack_i = ((cyc - endc) >= lo) && ((cyc - endc) <= hi);
            if (done_o) begin
                done_k = cyc - endc;
                got_ok = ok_o;
                if (poke_done) start_i = 1'b1;
                break;
            end
        end
        ack_i = 1'b0;

        chk(guard == 240, "R3", {name, " guard ticks"}, guard, 240);
        chk(bad_pause == 0, "R4", {name, " wrong pause widths"}, bad_pause, 0);
        chk(bad_mark == 0, "R4", {name, " wrong mark widths"}, bad_mark, 0);
        chk(falls == n + 1 && extra == 0, "R1", {name, " pause count"}, falls, n + 1);
        chk(got == exp, "R2", {name, " frame bits"}, int'(got), int'(exp));
        chk(done_k == exp_k, "R5", {name, " done timing"}, done_k, exp_k);
        chk(got_ok == exp_ok, "R5", {name, " ok at done"}, int'(got_ok), int'(exp_ok));

        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b0 && done_o == 1'b0, "R9", {name, " idle after done"},
            int'({busy_o, done_o}), 0);
        chk(ok_o == exp_ok, "R5", {name, " ok held"}, int'(ok_o), int'(exp_ok));
        if (poke_done) begin
            repeat (5) @(negedge clk);
            chk(busy_o == 1'b0 && tx_o == 1'b1, "R10", {name, " start in done cycle dropped"},
                int'({busy_o, tx_o}), 1);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_reset();
    endtask

    // R1 R2 R5: long address, acknowledge in the middle of the window
    task automatic t_long_ack_mid();
        run_cmd(10'h2B7, 8'hC5, 4'hA, 1'b1, D + 50, D + 60, 1'b1, D + 51, 1'b0, 1'b0, "long_mid");
    endtask

    // R1 R6 R7: short address with stray high bits, ack only before the window
    task automatic t_short_early_ack();
        run_cmd(10'h3A5, 8'h3C, 4'h6, 1'b0, 100, D - 1, 1'b0, D + W, 1'b0, 1'b0, "short_early");
    endtask

    // R8: ack only on the last window cycle
    task automatic t_ack_last_cycle();
        run_cmd(10'h1FF, 8'hFF, 4'hF, 1'b1, D + W - 1, D + W - 1, 1'b1, D + W, 1'b0, 1'b0, "ack_last");
    endtask

    // R5: ack on the first window cycle, all-zero fields
    task automatic t_ack_first_cycle();
        run_cmd(10'h000, 8'h00, 4'h0, 1'b0, D, D + 3, 1'b1, D + 1, 1'b0, 1'b0, "ack_first");
    endtask

    // R10: start pulses during the guard and in the done cycle
    task automatic t_start_while_busy();
        run_cmd(10'h155, 8'h5A, 4'h3, 1'b1, 0, -1, 1'b0, D + W, 1'b1, 1'b1, "busy_pokes");
    endtask

    initial begin
        t_reset();
        t_long_ack_mid();
        t_short_early_ack();
        t_ack_last_cycle();
        t_ack_first_cycle();
        t_start_while_busy();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule